// File: doc/BRIEF.md
# Sector Erase Command Sequencer

This block is the command front end of a parallel NOR-style memory. It watches bus write cycles, each one a single-cycle `we` strobe carrying an address and a data byte, and it recognises the six-write sector-erase command. When that command completes, an acceptance window opens. Sector-select writes that arrive while the window is open are queued in a one-bit-per-sector selection register, and each one restarts the window. When the window runs out with no further sector write, the erase phase begins. In this block the erase is a countdown of a fixed number of clock cycles.

While the erase runs, the only command acted on is erase suspend. A suspended erase holds its remaining count and continues when it receives the sector-erase code again. A `tmr_done` status bit tells software whether the acceptance window has closed. A synchronous reset abandons any sequence or erase at once.

Top module: `sector_erase_seq`

## Requirements
- R1: While `rst` is high, every output is driven to zero at the next clock edge: `win_open`, `erasing`, `suspended`, `tmr_done` and all bits of `sect_sel`.
- R2: The block decodes the low 11 address bits and the data byte of each write. The command sequence is (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0x80), (0x555, 0xAA), (0x2AA, 0x55), followed by a write of data 0x30 to any address. After the last write, `win_open` is 1 and `sect_sel` has the bit set whose index is `addr[14:11]`.
- R3: A write that does not match the next expected unlock or set-up cycle returns the block to read mode. No window opens and nothing is selected.
- R4: While the window is open, a write with data 0x30 sets one more bit in `sect_sel` and restarts the window. The write is taken if it is sampled no more than WIN_CYC clock edges after the previous sector write. A later write falls into the erase phase and is ignored.
- R5: The erase phase (`erasing` = 1) begins on the WIN_CYC-th clock edge after the last accepted sector write, if no sector write arrives in between.
- R6: `tmr_done` is 0 while the window is open or the block is idle. It is 1 throughout the erase phase and while the erase is suspended.
- R7: While the window is open, any write whose data is neither 0x30 nor 0xB0 closes the window, clears `sect_sel` and returns the block to read mode without erasing.
- R8: While the window is open, a write with data 0xB0 neither closes the window nor delays its expiry.
- R9: During the erase phase, every write except data 0xB0 is ignored, and `sect_sel` is unchanged.
- R10: During the erase phase, a write with data 0xB0 sets `suspended` and freezes the erase count. While suspended, only a write with data 0x30 resumes the erase, and the remaining count is kept.
- R11: After ERASE_CYC unsuspended erase cycles, the block returns to read mode with `sect_sel` cleared and `tmr_done` at 0.
- R12: A reset asserted during an erase ends the erase at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| we | input | 1 | Write strobe; one bus write per cycle in which it is high |
| addr | input | ADDR_W | Write address; bits 10:0 are the command address, the top bits are the sector index |
| wdata | input | 8 | Write data byte |
| win_open | output | 1 | Acceptance window is open |
| erasing | output | 1 | Erase countdown is running |
| suspended | output | 1 | Erase is suspended |
| tmr_done | output | 1 | Acceptance timer has expired (erase running or suspended) |
| sect_sel | output | SECT_N | One flag per selected sector |

## Verification
The bench targets the window boundary. It checks that a sector write sampled exactly WIN_CYC edges after the previous one is accepted, and that a write one edge later is ignored. A design with an off-by-one in the countdown either drops the first write or wrongly adds a sector to an erase already running. A suspend command sent during the window exposes a design that aborts on it or restarts its timer; that design shows the erase starting late, or never starting. The bench also suspends a running erase for a long stretch and then resumes it. A design that reloads the erase count on resume finishes late, and the cycle-by-cycle model comparison reports it. Broken unlock and set-up cycles, a foreign command inside the window, and a reset in the middle of an erase must each leave the selection empty.

// File: rtl/se_pkg.sv
package se_pkg;

    localparam int CMD_AW = 11;
    localparam int DATA_W = 8;

    localparam logic [CMD_AW-1:0] ADR_KEY_A = 11'h555;
    localparam logic [CMD_AW-1:0] ADR_KEY_B = 11'h2AA;
    localparam logic [DATA_W-1:0] DAT_KEY_A = 8'hAA;
    localparam logic [DATA_W-1:0] DAT_KEY_B = 8'h55;
    localparam logic [DATA_W-1:0] DAT_ARM   = 8'h80;
    localparam logic [DATA_W-1:0] DAT_SECT  = 8'h30;
    localparam logic [DATA_W-1:0] DAT_HOLD  = 8'hB0;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_KEY_A,
        CMD_KEY_B,
        CMD_ARM,
        CMD_SECT,
        CMD_HOLD,
        CMD_OTHER
    } cmd_e;

    typedef enum logic [3:0] {
        ST_READ,
        ST_K1,
        ST_K2,
        ST_ARMED,
        ST_K3,
        ST_K4,
        ST_WIN,
        ST_ERASE,
        ST_SUSP
    } seq_st_e;

    function automatic cmd_e classify(input logic v,
                                      input logic [CMD_AW-1:0] a,
                                      input logic [DATA_W-1:0] d);
        if (!v)                                 return CMD_NONE;
        if (a == ADR_KEY_A && d == DAT_KEY_A)   return CMD_KEY_A;
        if (a == ADR_KEY_B && d == DAT_KEY_B)   return CMD_KEY_B;
        if (a == ADR_KEY_A && d == DAT_ARM)     return CMD_ARM;
        if (d == DAT_SECT)                      return CMD_SECT;
        if (d == DAT_HOLD)                      return CMD_HOLD;
        return CMD_OTHER;
    endfunction

endpackage

// File: rtl/se_cmd_decode.sv
module se_cmd_decode
    import se_pkg::*;
(
    input  logic                we,
    input  logic [CMD_AW-1:0]   cmd_addr,
    input  logic [DATA_W-1:0]   wdata,
    output cmd_e                cmd
);
    always_comb cmd = classify(we, cmd_addr, wdata);
endmodule

// File: rtl/se_countdown.sv
module se_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_one
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (load)  cnt_q <= load_val;
        else if (dec)   cnt_q <= cnt_q - 1'b1;
    end

    assign is_one = (cnt_q == W'(1));
endmodule

// File: rtl/se_sector_flags.sv
module se_sector_flags #(
    parameter int SECT_N = 16,
    localparam int IW = $clog2(SECT_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic [IW-1:0]     set_idx,
    input  logic              clr,
    output logic [SECT_N-1:0] flags
);
    for (genvar i = 0; i < SECT_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst || clr)
                flags[i] <= 1'b0;
            else if (set_en && set_idx == IW'(i))
                flags[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/sector_erase_seq.sv
module sector_erase_seq
    import se_pkg::*;
#(
    parameter int SECT_N    = 16,
    parameter int ADDR_W    = 15,
    parameter int WIN_CYC   = 5000,
    parameter int ERASE_CYC = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              win_open,
    output logic              erasing,
    output logic              suspended,
    output logic              tmr_done,
    output logic [SECT_N-1:0] sect_sel
);
    localparam int SW    = $clog2(SECT_N);
    localparam int WIN_W = $clog2(WIN_CYC + 1);
    localparam int ER_W  = $clog2(ERASE_CYC + 1);

    seq_st_e st_q, st_d;
    cmd_e    cmd;
    logic    win_one, er_one;
    logic    win_load, win_quiet, win_dec, to_erase, abort_win;
    logic    er_run, er_dec, er_done;

    se_cmd_decode u_dec (
        .we       (we),
        .cmd_addr (addr[CMD_AW-1:0]),
        .wdata    (wdata),
        .cmd      (cmd)
    );

    always_comb begin
        win_load  = (st_q == ST_K4 || st_q == ST_WIN) && cmd == CMD_SECT;
        win_quiet = st_q == ST_WIN && (cmd == CMD_NONE || cmd == CMD_HOLD);
        win_dec   = win_quiet && !win_one;
        to_erase  = win_quiet && win_one;
        abort_win = st_q == ST_WIN && !(cmd == CMD_NONE || cmd == CMD_HOLD
                                        || cmd == CMD_SECT);
        er_run    = st_q == ST_ERASE && cmd != CMD_HOLD;
        er_dec    = er_run && !er_one;
        er_done   = er_run && er_one;
    end

    se_countdown #(.W(WIN_W)) u_win_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (win_load),
        .load_val (WIN_W'(WIN_CYC)),
        .dec      (win_dec),
        .is_one   (win_one)
    );

    se_countdown #(.W(ER_W)) u_er_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (to_erase),
        .load_val (ER_W'(ERASE_CYC)),
        .dec      (er_dec),
        .is_one   (er_one)
    );

    se_sector_flags #(.SECT_N(SECT_N)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_en  (win_load),
        .set_idx (addr[ADDR_W-1 -: SW]),
        .clr     (abort_win || er_done),
        .flags   (sect_sel)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_READ:  if (cmd != CMD_NONE) st_d = (cmd == CMD_KEY_A) ? ST_K1    : ST_READ;
            ST_K1:    if (cmd != CMD_NONE) st_d = (cmd == CMD_KEY_B) ? ST_K2    : ST_READ;
            ST_K2:    if (cmd != CMD_NONE) st_d = (cmd == CMD_ARM)   ? ST_ARMED : ST_READ;
            ST_ARMED: if (cmd != CMD_NONE) st_d = (cmd == CMD_KEY_A) ? ST_K3    : ST_READ;
            ST_K3:    if (cmd != CMD_NONE) st_d = (cmd == CMD_KEY_B) ? ST_K4    : ST_READ;
            ST_K4:    if (cmd != CMD_NONE) st_d = (cmd == CMD_SECT)  ? ST_WIN   : ST_READ;
            ST_WIN: begin
                if (abort_win)     st_d = ST_READ;
                else if (to_erase) st_d = ST_ERASE;
            end
            ST_ERASE: begin
                if (cmd == CMD_HOLD) st_d = ST_SUSP;
                else if (er_done)    st_d = ST_READ;
            end
            ST_SUSP:  if (cmd == CMD_SECT) st_d = ST_ERASE;
            default:  st_d = ST_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_READ;
        else     st_q <= st_d;
    end

    assign win_open  = (st_q == ST_WIN);
    assign erasing   = (st_q == ST_ERASE);
    assign suspended = (st_q == ST_SUSP);
    assign tmr_done  = (st_q == ST_ERASE) || (st_q == ST_SUSP);

endmodule

// File: rtl/se_seq_checker.sv
module se_seq_checker #(
    parameter int SECT_N = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              we,
    input logic [7:0]        wdata,
    input logic              win_open,
    input logic              erasing,
    input logic              suspended,
    input logic              tmr_done,
    input logic [SECT_N-1:0] sect_sel
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (sect_sel == '0 && !win_open && !erasing && !suspended && !tmr_done));

    assert_erase_from_window_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(erasing) |-> ($past(win_open) || $past(suspended)));

    assert_timer_low_in_window_R6: assert property (@(posedge clk) disable iff (rst)
        win_open |-> !tmr_done);

    assert_one_phase_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({win_open, erasing, suspended}));

    assert_abort_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (win_open && we && wdata != 8'h30 && wdata != 8'hB0)
        |=> (!win_open && !erasing && sect_sel == '0));

    assert_sel_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (erasing || suspended) |=> (sect_sel == $past(sect_sel) || sect_sel == '0));

    assert_erase_has_sector_R9: assert property (@(posedge clk) disable iff (rst)
        erasing |-> sect_sel != '0);

    assert_suspend_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (suspended && !(we && wdata == 8'h30)) |=> suspended);
endmodule

bind sector_erase_seq se_seq_checker #(.SECT_N(SECT_N)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .we        (we),
    .wdata     (wdata),
    .win_open  (win_open),
    .erasing   (erasing),
    .suspended (suspended),
    .tmr_done  (tmr_done),
    .sect_sel  (sect_sel)
);

// File: tb/sector_erase_seq_tb_top.sv
module sector_erase_seq_tb_top;
    localparam int SECT_N = 16;
    localparam int ADDR_W = 15;
    localparam int WIN    = 8;
    localparam int ERASE  = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic              win_open, erasing, suspended, tmr_done;
    logic [SECT_N-1:0] sect_sel;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    sector_erase_seq #(.SECT_N(SECT_N), .ADDR_W(ADDR_W), .WIN_CYC(WIN), .ERASE_CYC(ERASE)) dut_i (
        .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata),
        .win_open(win_open), .erasing(erasing), .suspended(suspended),
        .tmr_done(tmr_done), .sect_sel(sect_sel)
    );

    // Behavioural reference: 0 read, 1..5 sequence progress, 6 window, 7 erase, 8 suspended
    int          m_st = 0;
    int          m_w = 0;
    int          m_e = 0;
    logic [15:0] m_sel = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_w = 0; m_e = 0; m_sel = '0;
        end else begin
            case (m_st)
                0: if (we) m_st = (addr[10:0] == 11'h555 && wdata == 8'hAA) ? 1 : 0;
                1: if (we) m_st = (addr[10:0] == 11'h2AA && wdata == 8'h55) ? 2 : 0;
                2: if (we) m_st = (addr[10:0] == 11'h555 && wdata == 8'h80) ? 3 : 0;
                3: if (we) m_st = (addr[10:0] == 11'h555 && wdata == 8'hAA) ? 4 : 0;
                4: if (we) m_st = (addr[10:0] == 11'h2AA && wdata == 8'h55) ? 5 : 0;
                5: if (we) begin
                    if (wdata == 8'h30) begin
                        m_sel[addr[14:11]] = 1'b1; m_w = WIN; m_st = 6;
                    end else m_st = 0;
                end
                6: begin
                    if (we && wdata == 8'h30) begin
                        m_sel[addr[14:11]] = 1'b1; m_w = WIN;
                    end else if (we && wdata != 8'hB0) begin
                        m_st = 0; m_sel = '0;
                    end else if (m_w == 1) begin
                        m_st = 7; m_e = ERASE;
                    end else m_w = m_w - 1;
                end
                7: begin
                    if (we && wdata == 8'hB0) m_st = 8;
                    else if (m_e == 1) begin m_st = 0; m_sel = '0; end
                    else m_e = m_e - 1;
                end
                8: if (we && wdata == 8'h30) m_st = 7;
                default: m_st = 0;
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #2;
        chk(sect_sel == m_sel, "R4 model sect_sel", int'(sect_sel), int'(m_sel));
        chk(win_open == (m_st == 6), "R2 model win_open", int'(win_open), int'(m_st == 6));
        chk(erasing == (m_st == 7), "R11 model erasing", int'(erasing), int'(m_st == 7));
        chk(suspended == (m_st == 8), "R10 model suspended", int'(suspended), int'(m_st == 8));
        chk(tmr_done == (m_st >= 7), "R6 model tmr_done", int'(tmr_done), int'(m_st >= 7));
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog R11 actual=%0d expected<%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [ADDR_W-1:0] sa(input int s);
        return {4'(s), 11'h123};
    endfunction

    task automatic seq(input int s);
        wr(15'h555, 8'hAA); wr(15'h2AA, 8'h55); wr(15'h555, 8'h80);
        wr(15'h555, 8'hAA); wr(15'h2AA, 8'h55); wr(sa(s), 8'h30);
    endtask

    initial begin
        idle(3);
        chk(sect_sel == '0 && !win_open && !erasing && !suspended && !tmr_done,
            "R1 reset outputs", int'(sect_sel), 0);
        @(negedge clk); rst = 1'b0;
        idle(2);

        // Main flow: three sectors, last one at the accept boundary
        seq(3);
        chk(win_open == 1'b1, "R2 window opens", int'(win_open), 1);
        chk(sect_sel == 16'h0008, "R2 first sector", int'(sect_sel), 16'h0008);
        chk(tmr_done == 1'b0, "R6 timer low in window", int'(tmr_done), 0);
        idle(2); wr(sa(7), 8'h30);
        chk(sect_sel == 16'h0088, "R4 second sector", int'(sect_sel), 16'h0088);
        idle(WIN - 2); wr(sa(0), 8'h30);
        chk(win_open && sect_sel == 16'h0089, "R4 boundary write taken", int'(sect_sel), 16'h0089);
        idle(WIN - 1);
        chk(win_open == 1'b1, "R5 window still open", int'(win_open), 1);
        idle(1);
        chk(erasing == 1'b1, "R5 erase begins", int'(erasing), 1);
        chk(tmr_done == 1'b1, "R6 timer expired", int'(tmr_done), 1);
        wr(15'h555, 8'h80); wr(sa(9), 8'h30);
        chk(erasing && sect_sel == 16'h0089, "R9 writes ignored in erase", int'(sect_sel), 16'h0089);
        wr(15'h000, 8'hB0);
        chk(suspended == 1'b1, "R10 suspend", int'(suspended), 1);
        idle(10);
        chk(suspended && sect_sel == 16'h0089, "R10 held while suspended", int'(suspended), 1);
        wr(15'h000, 8'h30);
        chk(erasing == 1'b1, "R10 resume", int'(erasing), 1);
        for (int i = 0; i < 4 * ERASE && erasing; i++) @(negedge clk);
        chk(!erasing && sect_sel == '0 && !tmr_done, "R11 erase completes", int'(sect_sel), 0);

        // Broken unlock and broken set-up
        wr(15'h555, 8'hAA); wr(15'h2AA, 8'h56); wr(15'h555, 8'h80);
        wr(15'h555, 8'hAA); wr(15'h2AA, 8'h55); wr(sa(1), 8'h30);
        chk(!win_open && sect_sel == '0, "R3 bad unlock data", int'(win_open), 0);
        wr(15'h555, 8'hAA); wr(15'h2AA, 8'h55); wr(15'h555, 8'hA0);
        wr(15'h555, 8'hAA); wr(15'h2AA, 8'h55); wr(sa(1), 8'h30);
        chk(!win_open && sect_sel == '0, "R3 bad set-up data", int'(win_open), 0);

        // Foreign command aborts the window
        seq(5); wr(15'h000, 8'hF0);
        chk(!win_open && sect_sel == '0, "R7 abort clears", int'(sect_sel), 0);
        idle(WIN + 2);
        chk(!erasing && !tmr_done, "R7 no erase after abort", int'(erasing), 0);

        // Suspend inside the window: no abort, no extension
        seq(2); idle(1); wr(15'h000, 8'hB0);
        idle(WIN - 4);
        chk(win_open && !suspended, "R8 suspend ignored in window", int'(win_open), 1);
        idle(1);
        chk(erasing == 1'b1, "R8 expiry not delayed", int'(erasing), 1);

        // Reset mid-erase
        idle(3);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(!erasing && !tmr_done && sect_sel == '0, "R12 reset ends erase", int'(erasing), 0);

        // Late write falls into the erase phase
        seq(4); idle(WIN - 1); wr(sa(6), 8'h30);
        chk(erasing && sect_sel == 16'h0010, "R4 late write ignored", int'(sect_sel), 16'h0010);
        for (int i = 0; i < 4 * ERASE && erasing; i++) @(negedge clk);
        chk(!erasing && sect_sel == '0, "R11 second erase completes", int'(sect_sel), 0);

        idle(2);
        finish_run();
    end
endmodule